// File: doc/BRIEF.md
# External Bus Width Adapter

The adapter connects a 32-bit big-endian CPU access port to an external data bus that carries devices 8, 16 or 32 bits wide. The CPU chooses the device width with every request. The adapter puts each access on the correct byte lanes of the external bus. When an access is wider than the device, it breaks the access into consecutive device cycles, each with its own address. For reads, it collects the returned bytes into CPU bit order before it acknowledges. A narrow device always uses the low lanes of the external bus: an 8-bit device uses bits 7..0 and a 16-bit device uses bits 15..0.

The CPU holds `cpu_req` and its request fields steady until it sees a one-cycle `cpu_ack` or `cpu_err`. CPU data is right-justified: a byte travels in bits 7..0, a word in bits 15..0 and a longword in bits 31..0. Each device cycle is one strobe/ready exchange. The strobe stays high across all the cycles of a split access. The address, lanes and data move to the next cycle only after an edge at which ready was high.

Encodings used throughout: `cpu_size` 0 = byte, 1 = word, 2 = longword, 3 = reserved. `cpu_dev_width` 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. `dev_lane_en[i]` marks external bits 8i+7..8i.

Top module: `bus_width_adapter`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is zero.
- R2: A 32-bit device takes every access in one cycle at the request address. A byte at offset 0, 1, 2 or 3 uses lane_en 1000, 0100, 0010 or 0001. A word at offset 0 uses 1100 (bits 31..16) and a word at offset 2 uses 0011. A longword uses 1111.
- R3: On a 16-bit device, a byte at an even address uses lane_en 0010 (bits 15..8) and a byte at an odd address uses 0001. A word is one cycle with lane_en 0011. A longword is two cycles, at address A and A+2, that carry CPU bits 31..16 first and then 15..0.
- R4: On an 8-bit device, every cycle uses lane_en 0001. A word is two cycles, at A and A+1, high byte first. A longword is four cycles, at A to A+3, that carry CPU bits 31..24, 23..16, 15..8 and 7..0 in that order.
- R5: Read data comes back right-justified in `cpu_rdata`, with the bits above the access size set to zero.
- R6: In a write cycle, `dev_we` is high and the lanes not enabled are driven to zero. In a read cycle, `dev_we` is low and `dev_wdata` is zero.
- R7: `cpu_ack` is a one-cycle pulse in the cycle after the edge that completes the final device cycle. It never rises earlier and never rises together with `cpu_err`.
- R8: An instruction fetch is always a longword read from the request address with bits 1..0 cleared. `cpu_we` and `cpu_size` have no effect on it.
- R9: A data request is misaligned if it is a word at an odd address, a longword at an address that is not a multiple of 4, or uses size code 3. Such a request gives a one-cycle `cpu_err` and starts no device cycle.
- R10: The device width is taken when the request is accepted. Changing `cpu_dev_width` during the access has no effect on its cycles.
- R11: `dev_strobe` rises in the cycle after the request is accepted. It stays high, with address, lanes and data held, until ready is sampled high. The next cycle of a split access is presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU request, held until ack or err |
| cpu_we | input | 1 | 1 = write |
| cpu_ifetch | input | 1 | Instruction fetch flag |
| cpu_size | input | 2 | Access size code |
| cpu_dev_width | input | 2 | Device width code |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_ack | output | 1 | Access complete pulse |
| cpu_err | output | 1 | Misaligned request pulse |
| cpu_rdata | output | 32 | Right-justified read data |
| dev_strobe | output | 1 | Device cycle active |
| dev_we | output | 1 | Device cycle is a write |
| dev_addr | output | ADDR_W | Device cycle address |
| dev_lane_en | output | 4 | Active byte lanes |
| dev_wdata | output | 32 | External write data |
| dev_rdata | input | 32 | External read data |
| dev_ready | input | 1 | Device cycle complete |

## Verification
Each access size is tried on each device width, and offsets within the longword are walked. This separates the lane choice of a 32-bit device from the even/odd choice of a 16-bit device and from the fixed low lane of an 8-bit device. Split reads and writes run with zero, one and two wait cycles. These runs tell a correct high-part-first order and address increment apart from a reversed or repeated part, and show whether the outputs are held through the waits. The device answers with filler bytes on the lanes it does not use, so any masking fault appears in the assembled read data. Fetches at a 4n+2 address with the write flag set, misaligned requests, and a width change made in the middle of an access cover the forcing, rejection and sampling rules.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int CPU_W = 32;
  localparam int LANES = CPU_W / 8;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} acc_size_e;
  typedef enum logic [1:0] {DW_8 = 2'd0, DW_16 = 2'd1, DW_32 = 2'd2, DW_32X = 2'd3} dev_width_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} adp_state_e;
endpackage

// File: rtl/bwa_req_check.sv
module bwa_req_check
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 27
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  input  logic              ifetch,
  input  logic              we,
  output logic [ADDR_W-1:0] eff_addr,
  output acc_size_e         eff_size,
  output logic              eff_we,
  output logic              bad
);
  // A fetch is a longword read from the aligned address below it.
  always_comb begin
    eff_addr = ifetch ? {addr[ADDR_W-1:2], 2'b00} : addr;
    eff_size = ifetch ? SZ_LONG : size;
    eff_we   = we & ~ifetch;
    bad      = 1'b0;
    if (!ifetch) begin
      unique case (size)
        SZ_BYTE: bad = 1'b0;
        SZ_WORD: bad = addr[0];
        SZ_LONG: bad = |addr[1:0];
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bwa_lane_map.sv
module bwa_lane_map
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 27
) (
  input  acc_size_e         size,
  input  dev_width_e        width,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        beat,
  input  logic [CPU_W-1:0]  cpu_wdata,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [CPU_W-1:0]  dev_wdata,
  output logic [LANES-1:0]  lane_en,
  output logic [5:0]        dev_shift,
  output logic [5:0]        cpu_shift,
  output logic [CPU_W-1:0]  part_mask,
  output logic              last
);
  logic [1:0] slog, wlog, blog;
  logic [2:0] sb, wb, bb, dpos, cpos, done_bytes;
  logic [1:0] off;
  logic [3:0] lmask;

  always_comb begin
    unique case (size)
      SZ_BYTE: slog = 2'd0;
      SZ_WORD: slog = 2'd1;
      default: slog = 2'd2;
    endcase
    unique case (width)
      DW_8:    wlog = 2'd0;
      DW_16:   wlog = 2'd1;
      default: wlog = 2'd2;
    endcase
    // bytes moved per device cycle: the smaller of access and device width
    blog = (slog < wlog) ? slog : wlog;
    sb   = 3'd1 << slog;
    wb   = 3'd1 << wlog;
    bb   = 3'd1 << blog;
    beat_addr  = base + (ADDR_W'(beat) << blog);
    off        = beat_addr[1:0] & (wb[1:0] - 2'd1);
    // big-endian: lowest address sits in the highest lane of the device
    dpos       = wb - bb - {1'b0, off};
    done_bytes = (3'(beat) + 3'd1) << blog;
    cpos       = sb - done_bytes;
    dev_shift  = {dpos, 3'b000};
    cpu_shift  = {cpos, 3'b000};
    lmask      = (blog == 2'd0) ? 4'b0001 : (blog == 2'd1) ? 4'b0011 : 4'b1111;
    part_mask  = {{8{lmask[3]}}, {8{lmask[2]}}, {8{lmask[1]}}, {8{lmask[0]}}};
    lane_en    = lmask << dpos;
    dev_wdata  = ((cpu_wdata >> cpu_shift) & part_mask) << dev_shift;
    last       = (done_bytes == sb);
  end
endmodule

// File: rtl/bwa_read_pack.sv
module bwa_read_pack
  import bwa_pkg::*;
(
  input  logic [CPU_W-1:0] dev_rdata,
  input  logic [5:0]       dev_shift,
  input  logic [5:0]       cpu_shift,
  input  logic [CPU_W-1:0] part_mask,
  output logic [CPU_W-1:0] chunk
);
  always_comb chunk = ((dev_rdata >> dev_shift) & part_mask) << cpu_shift;
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_ifetch,
  input  logic [1:0]        cpu_size,
  input  logic [1:0]        cpu_dev_width,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ack,
  output logic              cpu_err,
  output logic [31:0]       cpu_rdata,
  output logic              dev_strobe,
  output logic              dev_we,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [3:0]        dev_lane_en,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata,
  input  logic              dev_ready
);
  adp_state_e        state;
  acc_size_e         size_q, eff_size, m_size;
  dev_width_e        width_q, m_width;
  logic [ADDR_W-1:0] base_q, eff_addr, m_base, map_addr;
  logic              we_q, eff_we, req_bad, issue_we, map_last, cap_last, accept;
  logic [1:0]        beat_q, m_beat;
  logic [CPU_W-1:0]  wdata_q, m_wdata, map_wdata, map_mask, cap_mask, acc_q, rd_chunk;
  logic [LANES-1:0]  map_lanes;
  logic [5:0]        map_dsh, map_csh, cap_dsh, cap_csh;

  bwa_req_check #(.ADDR_W(ADDR_W)) u_check (
    .addr(cpu_addr), .size(acc_size_e'(cpu_size)), .ifetch(cpu_ifetch), .we(cpu_we),
    .eff_addr(eff_addr), .eff_size(eff_size), .eff_we(eff_we), .bad(req_bad)
  );

  // Mapper looks one cycle ahead: the first part while idle, the next part while running.
  always_comb begin
    if (state == ST_IDLE) begin
      m_size = eff_size; m_width = dev_width_e'(cpu_dev_width); m_base = eff_addr;
      m_beat = 2'd0; m_wdata = cpu_wdata; issue_we = eff_we;
    end else begin
      m_size = size_q; m_width = width_q; m_base = base_q;
      m_beat = beat_q + 2'd1; m_wdata = wdata_q; issue_we = we_q;
    end
  end

  bwa_lane_map #(.ADDR_W(ADDR_W)) u_map (
    .size(m_size), .width(m_width), .base(m_base), .beat(m_beat), .cpu_wdata(m_wdata),
    .beat_addr(map_addr), .dev_wdata(map_wdata), .lane_en(map_lanes),
    .dev_shift(map_dsh), .cpu_shift(map_csh), .part_mask(map_mask), .last(map_last)
  );

  bwa_read_pack u_pack (
    .dev_rdata(dev_rdata), .dev_shift(cap_dsh), .cpu_shift(cap_csh),
    .part_mask(cap_mask), .chunk(rd_chunk)
  );

  assign accept = cpu_req && !cpu_ack && !cpu_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; size_q <= SZ_BYTE; width_q <= DW_8; base_q <= '0; we_q <= 1'b0;
      wdata_q <= '0; beat_q <= '0; acc_q <= '0; cap_dsh <= '0; cap_csh <= '0;
      cap_mask <= '0; cap_last <= 1'b0; cpu_ack <= 1'b0; cpu_err <= 1'b0; cpu_rdata <= '0;
      dev_strobe <= 1'b0; dev_we <= 1'b0; dev_addr <= '0; dev_lane_en <= '0; dev_wdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      cpu_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept && req_bad) begin
            cpu_err <= 1'b1;
          end else if (accept) begin
            size_q <= eff_size; width_q <= dev_width_e'(cpu_dev_width); base_q <= eff_addr;
            we_q <= eff_we; wdata_q <= cpu_wdata; beat_q <= 2'd0; acc_q <= '0;
            dev_strobe <= 1'b1; dev_we <= issue_we; dev_addr <= map_addr;
            dev_wdata <= issue_we ? map_wdata : '0; dev_lane_en <= map_lanes;
            cap_dsh <= map_dsh; cap_csh <= map_csh; cap_mask <= map_mask; cap_last <= map_last;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (dev_ready && cap_last) begin
            dev_strobe <= 1'b0; dev_we <= 1'b0; dev_wdata <= '0; dev_lane_en <= '0;
            cpu_ack <= 1'b1;
            if (!we_q) cpu_rdata <= acc_q | rd_chunk;
            state <= ST_IDLE;
          end else if (dev_ready) begin
            beat_q <= beat_q + 2'd1; acc_q <= acc_q | rd_chunk;
            dev_we <= issue_we; dev_addr <= map_addr;
            dev_wdata <= issue_we ? map_wdata : '0; dev_lane_en <= map_lanes;
            cap_dsh <= map_dsh; cap_csh <= map_csh; cap_mask <= map_mask; cap_last <= map_last;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [31:0] lane_bits;
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane_bits
    assign lane_bits[8*gi +: 8] = {8{dev_lane_en[gi]}};
  end

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    dev_strobe && !dev_ready |=> dev_strobe && $stable(dev_addr) && $stable(dev_lane_en) && $stable(dev_wdata))
    else $error("strobe cycle changed before ready"); // R11
  AST_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_ack) |-> $past(dev_strobe && dev_ready))
    else $error("ack without completed device cycle"); // R7
  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ack && cpu_err))
    else $error("ack and err together"); // R7
  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_err |-> !dev_strobe)
    else $error("device cycle started on error"); // R9
  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    dev_strobe |-> (dev_wdata & ~lane_bits) == 32'd0)
    else $error("unused lane driven"); // R6
  AST_READ_NO_WDATA: assert property (@(posedge clk) disable iff (rst)
    dev_strobe && !dev_we |-> dev_wdata == 32'd0)
    else $error("write data on read cycle"); // R6
  AST_FETCH_READS: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE && accept && cpu_ifetch |=> !dev_we)
    else $error("fetch issued as write"); // R8
endmodule

// File: tb/test_bus_width_adapter.sv
module test_bus_width_adapter;
  localparam int ADDR_W = 27;
  localparam int MEMSZ  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req = 1'b0, cpu_we = 1'b0, cpu_ifetch = 1'b0;
  logic [1:0]        cpu_size = 2'd0, cpu_dev_width = 2'd0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [31:0]       cpu_wdata = '0;
  logic              cpu_ack, cpu_err, dev_strobe, dev_we;
  logic [31:0]       cpu_rdata, dev_wdata;
  logic [ADDR_W-1:0] dev_addr;
  logic [3:0]        dev_lane_en;
  logic [31:0]       dev_rdata = '0;
  logic              dev_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mem [MEMSZ];

  always #10 clk = ~clk;

  bus_width_adapter #(.ADDR_W(ADDR_W)) i_bus_width_adapter (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ifetch(cpu_ifetch),
    .cpu_size(cpu_size), .cpu_dev_width(cpu_dev_width), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .dev_strobe(dev_strobe), .dev_we(dev_we), .dev_addr(dev_addr), .dev_lane_en(dev_lane_en),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ready(dev_ready)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Device model: a big-endian byte store seen through a bus of W bytes; unused lanes carry filler.
  function automatic logic [31:0] dev_bus(input int a, input int w);
    logic [31:0] v = 32'hEEEE_EEEE;
    int base = a - (a % w);
    for (int j = 0; j < w; j++) v[8*j +: 8] = mem[(base + w - 1 - j) % MEMSZ];
    return v;
  endfunction

  task automatic access(input int addr, input int size, input bit we, input logic [31:0] wd,
                        input bit ifetch, input int wcode, input int waits, input bit chg,
                        input string tag);
    int s, w, b, ea, nb, pos, wcnt;
    bit bad, we_eff, ack_due, done;
    int baddr [4];
    logic [3:0]  lanes [4];
    logic [31:0] data [4];
    logic [31:0] exp_rd;
    string wtag;
    ea     = ifetch ? (addr & ~3) : addr;
    s      = ifetch ? 4 : (size == 0 ? 1 : size == 1 ? 2 : 4);
    we_eff = we && !ifetch;
    bad    = !ifetch && (size == 3 || (size == 1 && addr % 2 != 0) || (size == 2 && addr % 4 != 0));
    w      = wcode == 0 ? 1 : wcode == 1 ? 2 : 4;
    b      = s < w ? s : w;
    nb     = s / b;
    wtag   = ifetch ? "R8" : "R6";
    for (int k = 0; k < 4; k++) begin baddr[k] = ea + k * b; lanes[k] = '0; data[k] = '0; end
    exp_rd = '0;
    for (int i = 0; i < s; i++) begin
      int k = i / b;
      int ln = w - 1 - ((ea + i) % w);
      lanes[k][ln] = 1'b1;
      data[k] = data[k] | (32'(wd[8*(s-1-i) +: 8]) << (8 * ln));
      exp_rd = (exp_rd << 8) | 32'(mem[(ea + i) % MEMSZ]);
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = ADDR_W'(addr); cpu_size = 2'(size); cpu_we = we;
    cpu_wdata = wd; cpu_ifetch = ifetch; cpu_dev_width = 2'(wcode);
    pos = 0; wcnt = waits; ack_due = 1'b0; done = 1'b0;
    for (int cyc = 0; cyc < 80 && !done; cyc++) begin
      @(negedge clk);
      if (bad) begin
        chk(cpu_err === 1'b1 && dev_strobe === 1'b0 && cpu_ack === 1'b0, "R9",
            {30'd0, cpu_err, dev_strobe}, 32'h2, "error pulse without device cycle");
        cpu_req = 1'b0;
        @(negedge clk);
        chk(cpu_err === 1'b0 && dev_strobe === 1'b0, "R9",
            {30'd0, cpu_err, dev_strobe}, 32'h0, "no cycle after error");
        done = 1'b1;
      end else if (ack_due) begin
        chk(cpu_ack === 1'b1 && cpu_err === 1'b0, "R7", {30'd0, cpu_ack, cpu_err}, 32'h2,
            "ack after final ready");
        if (!we_eff) chk(cpu_rdata === exp_rd, "R5", cpu_rdata, exp_rd, "assembled read data");
        cpu_req = 1'b0; dev_ready = 1'b0;
        @(negedge clk);
        chk(cpu_ack === 1'b0 && dev_strobe === 1'b0, "R7", {30'd0, cpu_ack, dev_strobe}, 32'h0,
            "single ack pulse and idle bus");
        done = 1'b1;
      end else begin
        chk(cpu_ack === 1'b0 && cpu_err === 1'b0, "R7", {30'd0, cpu_ack, cpu_err}, 32'h0,
            "no early ack");
        if (chg && cyc == 0) cpu_dev_width = 2'((wcode + 1) % 3);
        chk(dev_strobe === 1'b1, "R11", {31'd0, dev_strobe}, 32'h1, "strobe until last ready");
        if (dev_strobe === 1'b1 && pos < nb) begin
          chk(dev_addr === ADDR_W'(baddr[pos]), tag, 32'(dev_addr), 32'(baddr[pos]), "cycle address");
          chk(dev_lane_en === lanes[pos], tag, 32'(dev_lane_en), 32'(lanes[pos]), "lane enables");
          chk(dev_we === we_eff, wtag, 32'(dev_we), 32'(we_eff), "cycle direction");
          chk(dev_wdata === (we_eff ? data[pos] : 32'd0), "R6", dev_wdata,
              we_eff ? data[pos] : 32'd0, "external write data");
          dev_rdata = dev_bus(baddr[pos], w);
          if (wcnt > 0) begin
            dev_ready = 1'b0; wcnt--;
          end else begin
            dev_ready = 1'b1;
            if (we_eff) begin
              int base = baddr[pos] - (baddr[pos] % w);
              for (int j = 0; j < w; j++)
                if (lanes[pos][j]) mem[(base + w - 1 - j) % MEMSZ] = dev_wdata[8*j +: 8];
            end
            pos++; wcnt = waits;
            if (pos == nb) ack_due = 1'b1;
          end
        end
      end
    end
    if (!done) chk(1'b0, tag, 32'(pos), 32'(nb), "access did not finish");
    dev_ready = 1'b0; cpu_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(8'hA0 + i * 5);
    repeat (3) @(negedge clk);
    chk(cpu_ack === 1'b0 && cpu_err === 1'b0 && dev_strobe === 1'b0 && dev_we === 1'b0,
        "R1", {28'd0, cpu_ack, cpu_err, dev_strobe, dev_we}, 32'h0, "control outputs in reset");
    chk(cpu_rdata === 32'd0 && dev_wdata === 32'd0 && dev_lane_en === 4'd0 && dev_addr === '0,
        "R1", cpu_rdata | dev_wdata, 32'h0, "data outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(dev_strobe === 1'b0 && cpu_ack === 1'b0, "R1", {30'd0, dev_strobe, cpu_ack}, 32'h0,
        "idle after reset");
    // 32-bit device lanes
    for (int o = 0; o < 4; o++) access(o, 0, 1'b0, 32'h0, 1'b0, 2, o % 2, 1'b0, "R2");
    access(0, 1, 1'b0, 32'h0, 1'b0, 2, 0, 1'b0, "R2");
    access(2, 1, 1'b0, 32'h0, 1'b0, 2, 1, 1'b0, "R2");
    access(4, 2, 1'b0, 32'h0, 1'b0, 2, 0, 1'b0, "R2");
    // 16-bit device
    access(5, 0, 1'b0, 32'h0, 1'b0, 1, 0, 1'b0, "R3");
    access(6, 0, 1'b0, 32'h0, 1'b0, 1, 1, 1'b0, "R3");
    access(8, 1, 1'b0, 32'h0, 1'b0, 1, 0, 1'b0, "R3");
    access(12, 2, 1'b0, 32'h0, 1'b0, 1, 2, 1'b0, "R3");
    // 8-bit device
    access(3, 0, 1'b0, 32'h0, 1'b0, 0, 0, 1'b0, "R4");
    access(10, 1, 1'b0, 32'h0, 1'b0, 0, 1, 1'b0, "R4");
    access(16, 2, 1'b0, 32'h0, 1'b0, 0, 0, 1'b0, "R4");
    access(20, 2, 1'b0, 32'h0, 1'b0, 0, 2, 1'b0, "R4");
    // writes on each width, then read back on other widths
    access(1, 0, 1'b1, 32'hFFFF_FF5A, 1'b0, 2, 0, 1'b0, "R2");
    access(20, 2, 1'b1, 32'h1122_3344, 1'b0, 1, 1, 1'b0, "R3");
    access(26, 1, 1'b1, 32'hDEAD_BEEF, 1'b0, 0, 0, 1'b0, "R4");
    access(3, 0, 1'b1, 32'h0000_00C3, 1'b0, 1, 0, 1'b0, "R3");
    access(0, 2, 1'b0, 32'h0, 1'b0, 2, 0, 1'b0, "R2");
    access(20, 2, 1'b0, 32'h0, 1'b0, 2, 0, 1'b0, "R2");
    access(26, 1, 1'b0, 32'h0, 1'b0, 1, 1, 1'b0, "R3");
    // instruction fetches
    access(14, 0, 1'b1, 32'hCAFE_F00D, 1'b1, 1, 0, 1'b0, "R8");
    access(7, 1, 1'b0, 32'h0, 1'b1, 0, 1, 1'b0, "R8");
    access(18, 2, 1'b1, 32'h1234_5678, 1'b1, 2, 0, 1'b0, "R8");
    // misaligned requests
    access(3, 1, 1'b0, 32'h0, 1'b0, 2, 0, 1'b0, "R9");
    access(6, 2, 1'b1, 32'h5555_AAAA, 1'b0, 1, 0, 1'b0, "R9");
    access(8, 3, 1'b0, 32'h0, 1'b0, 0, 0, 1'b0, "R9");
    // width changed while an access runs
    access(24, 2, 1'b0, 32'h0, 1'b0, 0, 1, 1'b1, "R10");
    access(28, 2, 1'b1, 32'h0BAD_CAFE, 1'b0, 1, 2, 1'b1, "R10");
    access(28, 2, 1'b0, 32'h0, 1'b0, 2, 0, 1'b0, "R10");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule